// File: doc/BRIEF.md
# Time-Multiplexed Leaky Integrate-and-Fire Neuron Engine

The engine evaluates a population of virtual leaky integrate-and-fire neurons on a single shared arithmetic datapath. Each neuron's decay factor, firing threshold and synapse count sit in a neuron context memory, and its membrane potential sits in a potential memory. Each synapse's weight and presynaptic source address sit in a synapse context memory. A sequencer pulses `start`, and the engine then walks the neurons in index order. For each neuron it decays the membrane potential, then takes that neuron's synapses one after another. Each synapse looks up its presynaptic activity bit in a local copy of the whole network state and, when that bit is set, adds its weight plus a noise sample.

After the last synapse of a neuron, the engine compares the potential with the threshold plus a second noise sample. It writes the resulting spike bit into a local next-state memory, ready for a later broadcast, and writes the new potential back. Both noise samples come from two small tables indexed by a shared 16-bit LFSR.

A narrow write port fills every local memory, and a read port returns a neuron's spike bit and potential. When the whole pass has been written back, the engine issues a one-cycle `done` to the sequencer.

Top module: `spike_neuron_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy` and `done` are low.
- R2: A write with `cfg_we` high while idle stores `cfg_data` into the memory chosen by `cfg_sel`:
  - 0 selects the neuron context: decay in bits [15:0], threshold in [31:16], synapse count in [31+CNT_W:32].
  - 1 selects the synapse context: weight in [15:0], source address above it.
  - 2 selects the network-state copy bit, taken from bit 0.
  - 3 selects a noise entry in [15:0]. Address bit NOISE_AW picks the threshold table when 1 and the synaptic table when 0.
  - 4 selects a membrane potential in [15:0].
  Writes presented while `busy` is high are dropped.
- R3: A `start` pulse while idle raises `busy` on the next cycle. Neurons are then processed in index order. Each neuron consumes its synapse count of consecutive synapse entries, and the entries are counted from 0 for every pass.
- R4: A synapse adds (weight + synaptic noise) to the accumulator only when the network-state bit at its source address is 1. Otherwise it adds nothing.
- R5: The decayed potential is (v × decay) shifted right arithmetically by 15, which rounds toward minus infinity. Both operands are 16-bit signed.
- R6: A neuron spikes when its accumulated value is greater than or equal to threshold + threshold noise. A spiking neuron's potential becomes 0.
- R7: A non-spiking neuron's new potential is its accumulated value saturated to the 16-bit signed range.
- R8: The LFSR has taps 16, 14, 13 and 11 and is seeded with 0xACE1 at reset. It shifts left and feeds back into bit 0. Its low NOISE_AW bits index a table. It advances once for every synapse processed and once for every threshold test, and it keeps its state from one pass to the next.
- R9: Each neuron's spike bit is written into the next-state memory. `rd_spike` and `rd_pot` return the values at `rd_addr` one cycle after it is presented, while idle.
- R10: `done` is high for exactly one cycle. It follows the last neuron's write, and `busy` is low in that same cycle.
- R11: A `start` pulse while `busy` is high has no effect on the pass or on the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an update pass |
| busy | output | 1 | Update pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| cfg_we | input | 1 | Memory write strobe |
| cfg_sel | input | 3 | Target memory select |
| cfg_addr | input | CFG_AW | Write address |
| cfg_data | input | 2*DATA_W+CNT_W | Write data |
| rd_addr | input | clog2(N_NEURON) | Neuron to read back |
| rd_spike | output | 1 | Next-state spike bit of that neuron |
| rd_pot | output | DATA_W | Membrane potential of that neuron |

## Verification
The bench builds the engine with 6 neurons, 24 synapses, a 16-bit network state, 8-entry noise tables and a 4-bit synapse count. At this size every neuron and every synapse slot can be filled and read back on every pass. A hand-built first pass hits the corners directly: zero-synapse neurons, exact threshold equality, negative rounding of the decay and negative saturation. Seven further generated passes carry potentials and the LFSR state across passes, so the bench's own arithmetic model is compared against every neuron's spike and potential each time. Each pass also injects a restart pulse and a potential write while busy.

// File: rtl/snn_pkg.sv
package snn_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_NRD, ST_NLD, ST_SRD, ST_SLD, ST_SACC, ST_TRD, ST_TCMP, ST_FIN
  } eng_state_t;

  localparam logic [2:0] SEL_NEURON = 3'd0;
  localparam logic [2:0] SEL_SYN    = 3'd1;
  localparam logic [2:0] SEL_NET    = 3'd2;
  localparam logic [2:0] SEL_NOISE  = 3'd3;
  localparam logic [2:0] SEL_POT    = 3'd4;
endpackage

// File: rtl/sdp_ram.sv
// Simple dual-port memory: one synchronous write, one registered read.
module sdp_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/noise_lfsr.sv
// 16-bit maximal-length pseudo-random index source.
module noise_lfsr #(
  parameter int          IDX_W = 4,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  logic [15:0] q;
  logic        fb;

  assign fb  = q[15] ^ q[13] ^ q[12] ^ q[10];
  assign idx = q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)      q <= SEED;
    else if (adv) q <= {q[14:0], fb};
  end

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) q != 16'h0);
  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(q));
  // R8
  lfsr_move_chk: assert property (@(posedge clk) disable iff (rst) adv |=> q != $past(q));
endmodule

// File: rtl/lif_alu.sv
// Shared neuron arithmetic: decay, noisy weight, threshold compare, saturation.
module lif_alu #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 28
) (
  input  logic signed [DATA_W-1:0] v,
  input  logic signed [DATA_W-1:0] decay,
  input  logic signed [DATA_W-1:0] w,
  input  logic signed [DATA_W-1:0] w_noise,
  input  logic signed [DATA_W-1:0] thr,
  input  logic signed [DATA_W-1:0] t_noise,
  input  logic signed [ACC_W-1:0]  acc,
  output logic signed [ACC_W-1:0]  decayed,
  output logic signed [ACC_W-1:0]  noisy_w,
  output logic                     spike,
  output logic signed [DATA_W-1:0] v_next
);
  localparam int MUL_W = 18;
  localparam int FRAC  = 15;
  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((1 << (DATA_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(1 << (DATA_W-1));

  logic signed [MUL_W-1:0]   v_x, d_x;
  logic signed [2*MUL_W-1:0] prod, shifted;
  logic signed [ACC_W-1:0]   limit;

  always_comb begin
    v_x     = MUL_W'(v);
    d_x     = MUL_W'(decay);
    prod    = v_x * d_x;
    shifted = prod >>> FRAC;
    decayed = ACC_W'(shifted);
    noisy_w = ACC_W'(w) + ACC_W'(w_noise);
    limit   = ACC_W'(thr) + ACC_W'(t_noise);
    spike   = (acc >= limit);
    if (spike)              v_next = '0;
    else if (acc > MAX_V)   v_next = MAX_V[DATA_W-1:0];
    else if (acc < MIN_V)   v_next = MIN_V[DATA_W-1:0];
    else                    v_next = acc[DATA_W-1:0];
  end
endmodule

// File: rtl/spike_neuron_engine.sv
module spike_neuron_engine
  import snn_pkg::*;
#(
  parameter int          N_NEURON  = 112,
  parameter int          N_SYN     = 912,
  parameter int          NET_BITS  = 1024,
  parameter int          DATA_W    = 16,
  parameter int          CNT_W     = 8,
  parameter int          NOISE_AW  = 4,
  parameter int          CFG_AW    = 10,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  output logic                          busy,
  output logic                          done,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_sel,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [2*DATA_W+CNT_W-1:0]     cfg_data,
  input  logic [$clog2(N_NEURON)-1:0]   rd_addr,
  output logic                          rd_spike,
  output logic [DATA_W-1:0]             rd_pot
);
  localparam int NEU_AW = $clog2(N_NEURON);
  localparam int SYN_AW = $clog2(N_SYN);
  localparam int SRC_W  = $clog2(NET_BITS);
  localparam int NCTX_W = 2*DATA_W + CNT_W;
  localparam int SCTX_W = DATA_W + SRC_W;
  localparam int ACC_W  = DATA_W + 2 + SYN_AW;
  localparam int NZ_AW  = NOISE_AW + 1;
  localparam int NZ_DEP = 1 << NZ_AW;
  localparam logic [NEU_AW-1:0] LAST_N = NEU_AW'(N_NEURON - 1);

  eng_state_t st;
  logic [NEU_AW-1:0]       nidx;
  logic [SYN_AW-1:0]       sidx;
  logic [CNT_W-1:0]        remain;
  logic signed [ACC_W-1:0] acc, nw_q;

  logic                    cfg_ok, cfg_pot, eng_we;
  logic [NCTX_W-1:0]       nctx;
  logic [SCTX_W-1:0]       sctx;
  logic                    net_bit;
  logic [DATA_W-1:0]       nz;
  logic [DATA_W-1:0]       pot_rd;
  logic [NOISE_AW-1:0]     lfsr_idx;
  logic                    lfsr_adv;

  logic                    pot_we;
  logic [NEU_AW-1:0]       pot_waddr, pot_raddr;
  logic [DATA_W-1:0]       pot_wdata;

  logic signed [ACC_W-1:0]  decayed, noisy_w;
  logic                     spike;
  logic signed [DATA_W-1:0] v_next;

  assign busy     = (st != ST_IDLE);
  assign cfg_ok   = cfg_we && !busy;
  assign cfg_pot  = cfg_ok && (cfg_sel == SEL_POT);
  assign eng_we   = (st == ST_TCMP);
  assign lfsr_adv = (st == ST_SRD) || (st == ST_TRD);

  // Context and state memories
  sdp_ram #(.W(NCTX_W), .DEPTH(N_NEURON)) u_nctx (
    .clk(clk), .we(cfg_ok && cfg_sel == SEL_NEURON), .waddr(cfg_addr[NEU_AW-1:0]),
    .wdata(cfg_data), .raddr(nidx), .rdata(nctx));

  sdp_ram #(.W(SCTX_W), .DEPTH(N_SYN)) u_sctx (
    .clk(clk), .we(cfg_ok && cfg_sel == SEL_SYN), .waddr(cfg_addr[SYN_AW-1:0]),
    .wdata(cfg_data[SCTX_W-1:0]), .raddr(sidx), .rdata(sctx));

  sdp_ram #(.W(1), .DEPTH(NET_BITS)) u_net (
    .clk(clk), .we(cfg_ok && cfg_sel == SEL_NET), .waddr(cfg_addr[SRC_W-1:0]),
    .wdata(cfg_data[0]), .raddr(sctx[SCTX_W-1:DATA_W]), .rdata(net_bit));

  sdp_ram #(.W(DATA_W), .DEPTH(NZ_DEP)) u_noise (
    .clk(clk), .we(cfg_ok && cfg_sel == SEL_NOISE), .waddr(cfg_addr[NZ_AW-1:0]),
    .wdata(cfg_data[DATA_W-1:0]), .raddr({st == ST_TRD, lfsr_idx}), .rdata(nz));

  assign pot_we    = cfg_pot || eng_we;
  assign pot_waddr = cfg_pot ? cfg_addr[NEU_AW-1:0] : nidx;
  assign pot_wdata = cfg_pot ? cfg_data[DATA_W-1:0] : v_next;
  assign pot_raddr = busy ? nidx : rd_addr;

  sdp_ram #(.W(DATA_W), .DEPTH(N_NEURON)) u_pot (
    .clk(clk), .we(pot_we), .waddr(pot_waddr), .wdata(pot_wdata),
    .raddr(pot_raddr), .rdata(pot_rd));

  sdp_ram #(.W(1), .DEPTH(N_NEURON)) u_next (
    .clk(clk), .we(eng_we), .waddr(nidx), .wdata(spike),
    .raddr(rd_addr), .rdata(rd_spike));

  assign rd_pot = pot_rd;

  noise_lfsr #(.IDX_W(NOISE_AW), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv(lfsr_adv), .idx(lfsr_idx));

  lif_alu #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_alu (
    .v(pot_rd), .decay(nctx[DATA_W-1:0]), .w(sctx[DATA_W-1:0]), .w_noise(nz),
    .thr(nctx[2*DATA_W-1:DATA_W]), .t_noise(nz), .acc(acc),
    .decayed(decayed), .noisy_w(noisy_w), .spike(spike), .v_next(v_next));

  // Sequencing: one neuron context at a time, synapses consecutively
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      done   <= 1'b0;
      nidx   <= '0;
      sidx   <= '0;
      remain <= '0;
      acc    <= '0;
      nw_q   <= '0;
    end else begin
      done <= (st == ST_FIN);
      unique case (st)
        ST_IDLE: if (start) begin
          nidx <= '0;
          sidx <= '0;
          st   <= ST_NRD;
        end
        ST_NRD: st <= ST_NLD;
        ST_NLD: begin
          acc    <= decayed;
          remain <= nctx[NCTX_W-1:2*DATA_W];
          st     <= (nctx[NCTX_W-1:2*DATA_W] == '0) ? ST_TRD : ST_SRD;
        end
        ST_SRD: st <= ST_SLD;
        ST_SLD: begin
          nw_q <= noisy_w;
          st   <= ST_SACC;
        end
        ST_SACC: begin
          if (net_bit) acc <= acc + nw_q;
          sidx   <= sidx + SYN_AW'(1);
          remain <= remain - CNT_W'(1);
          st     <= (remain == CNT_W'(1)) ? ST_TRD : ST_SRD;
        end
        ST_TRD: st <= ST_TCMP;
        ST_TCMP: begin
          if (nidx == LAST_N) st <= ST_FIN;
          else begin
            nidx <= nidx + NEU_AW'(1);
            st   <= ST_NRD;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(eng_we, 2) && $past(nidx, 2) == LAST_N && !busy));
  // R11
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && st != ST_TCMP) |=> $stable(nidx));
  // R2
  cfg_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (pot_we && busy) |-> (pot_waddr == nidx && st == ST_TCMP));
  // R6
  spike_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_we && spike) |-> pot_wdata == '0);
  // R3
  syn_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SACC) |-> remain != '0);
endmodule

// File: tb/spike_neuron_engine_tb.sv
module spike_neuron_engine_tb;
  localparam int NN = 6, NS = 24, NB = 16, DW = 16, CW = 4, NZA = 3, CAW = 5;
  localparam int CDW = 2*DW + CW;
  localparam int NZE = 1 << NZA;

  logic clk = 0, rst = 1, start = 0, cfg_we = 0;
  logic [2:0] cfg_sel = '0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [CDW-1:0] cfg_data = '0;
  logic [2:0] rd_addr = '0;
  logic busy, done, rd_spike;
  logic [DW-1:0] rd_pot;

  always #10 clk = ~clk;

  spike_neuron_engine #(.N_NEURON(NN), .N_SYN(NS), .NET_BITS(NB), .DATA_W(DW),
    .CNT_W(CW), .NOISE_AW(NZA), .CFG_AW(CAW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rd_addr(rd_addr), .rd_spike(rd_spike), .rd_pot(rd_pot));

  int n_chk = 0, n_bad = 0;
  int m_decay[NN], m_thr[NN], m_cnt[NN], m_pot[NN];
  int m_w[NS], m_src[NS], m_zs[NZE], m_zt[NZE];
  bit m_net[NB], m_spk[NN];
  logic [15:0] m_lfsr = 16'hACE1;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return lo + (int'(seed[31:8]) % (hi - lo + 1));
  endfunction

  function automatic logic [15:0] lstep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic cfg(input logic [2:0] sel, input int addr, input logic [CDW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_addr = CAW'(addr); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load_all();
    for (int n = 0; n < NN; n++) begin
      cfg(3'd0, n, {CW'(m_cnt[n]), 16'(m_thr[n]), 16'(m_decay[n])});
      cfg(3'd4, n, CDW'(16'(m_pot[n])));
    end
    for (int s = 0; s < NS; s++) cfg(3'd1, s, CDW'({4'(m_src[s]), 16'(m_w[s])}));
    for (int b = 0; b < NB; b++) cfg(3'd2, b, CDW'(m_net[b]));
    for (int i = 0; i < NZE; i++) begin
      cfg(3'd3, i, CDW'(16'(m_zs[i])));
      cfg(3'd3, NZE + i, CDW'(16'(m_zt[i])));
    end
  endtask

  // Independent arithmetic model of one pass (R3-R8)
  task automatic model_pass();
    int sp = 0;
    for (int n = 0; n < NN; n++) begin
      int acc = (m_pot[n] * m_decay[n]) >>> 15;
      int lim;
      for (int k = 0; k < m_cnt[n]; k++) begin
        int z = m_zs[m_lfsr[NZA-1:0]];
        m_lfsr = lstep(m_lfsr);
        if (m_net[m_src[sp]]) acc += m_w[sp] + z;
        sp++;
      end
      lim = m_thr[n] + m_zt[m_lfsr[NZA-1:0]];
      m_lfsr = lstep(m_lfsr);
      m_spk[n] = (acc >= lim);
      if (m_spk[n])        m_pot[n] = 0;
      else if (acc > 32767)  m_pot[n] = 32767;
      else if (acc < -32768) m_pot[n] = -32768;
      else                   m_pot[n] = acc;
    end
  endtask

  task automatic run_epoch(input int ep);
    int cyc = 0, dones = 0;
    bit seen = 0;
    model_pass();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(busy === 1'b1, "R3 busy after start", int'(busy), 1);
    while (!seen && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 3) begin
        // R11 restart pulse and R2 write while busy, both must be dropped
        start = 1; cfg_we = 1; cfg_sel = 3'd4; cfg_addr = CAW'(NN-1); cfg_data = CDW'(16'h8AD0);
      end else begin
        start = 0; cfg_we = 0;
      end
      if (done) begin
        seen = 1; dones++;
        check(busy === 1'b0, "R10 busy low with done", int'(busy), 0);
      end
    end
    check(seen, "R10 done reached", int'(seen), 1);
    @(negedge clk);
    check(done === 1'b0, "R10 done single cycle", int'(done), 0);
    repeat (4) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 1, "R11 one done per pass", dones, 1);
    for (int n = 0; n < NN; n++) begin
      @(negedge clk) rd_addr = 3'(n);
      @(negedge clk);
      check(rd_spike === m_spk[n], $sformatf("R9 R6 spike ep%0d n%0d", ep, n), int'(rd_spike), int'(m_spk[n]));
      check($signed(rd_pot) == m_pot[n], $sformatf("R5 R7 potential ep%0d n%0d", ep, n), int'($signed(rd_pot)), m_pot[n]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 in reset", int'(busy) + int'(done), 0);
    rst = 0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 after reset", int'(busy) + int'(done), 0);

    // Pass 0: hand-built corners, noise tables zero
    for (int i = 0; i < NZE; i++) begin m_zs[i] = 0; m_zt[i] = 0; end
    for (int b = 0; b < NB; b++) m_net[b] = (b == 1 || b == 2);
    for (int s = 0; s < NS; s++) begin m_w[s] = 0; m_src[s] = 0; end
    m_pot[0] = -3;     m_decay[0] = 16'h4000; m_cnt[0] = 0; m_thr[0] = 100;   // R5 floor -2
    m_pot[1] = 0;      m_decay[1] = 16'h7000; m_cnt[1] = 2; m_thr[1] = 100;   // R6 equality
    m_w[0] = 40; m_src[0] = 1; m_w[1] = 60; m_src[1] = 2;
    m_pot[2] = 50;     m_decay[2] = 16'h7FFF; m_cnt[2] = 2; m_thr[2] = 200;   // R4 inactive source
    m_w[2] = 1000; m_src[2] = 3; m_w[3] = 5; m_src[3] = 1;
    m_pot[3] = -30000; m_decay[3] = 16'h7FFF; m_cnt[3] = 3; m_thr[3] = 0;     // R7 saturation
    for (int s = 4; s < 7; s++) begin m_w[s] = -30000; m_src[s] = 1; end
    m_pot[4] = 0;      m_decay[4] = 16'h2000; m_cnt[4] = 4; m_thr[4] = -5;    // R6 negative threshold
    m_pot[5] = 0;      m_decay[5] = 0;        m_cnt[5] = 1; m_thr[5] = 99;
    m_w[11] = 99; m_src[11] = 2;
    load_all();
    run_epoch(0);

    // Passes 1..7: generated contexts, potentials and LFSR carried over (R8)
    for (int ep = 1; ep < 8; ep++) begin
      for (int i = 0; i < NZE; i++) begin m_zs[i] = rnd(-64, 64); m_zt[i] = rnd(-64, 64); end
      for (int b = 0; b < NB; b++) m_net[b] = bit'(rnd(0, 1));
      for (int n = 0; n < NN; n++) begin
        m_decay[n] = rnd(0, 32767); m_thr[n] = rnd(-200, 800); m_cnt[n] = rnd(0, 4);
      end
      for (int s = 0; s < NS; s++) begin m_w[s] = rnd(-300, 600); m_src[s] = rnd(0, NB-1); end
      load_all();
      run_epoch(ep);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule